// File: doc/BRIEF.md
# Packet-Tagged Receive FIFO

This block sits between a bit-oriented link-layer deframer and a processor. The deframer handles flag hunting, bit destuffing and checksum checking. It hands this block three things: received bytes, a 2-bit tag per byte that gives the byte's place in its packet, and a strobe each time it sees an opening flag. The block stores each byte together with its tag in a 16-entry queue. The processor pops bytes from the head and sees the head byte's tag beside the data, so it knows where packets begin and end.

Two interrupt sources are kept. One says that a packet end has just been written into the queue. The other says that the byte now at the head, the next one to be popped, ends a packet. Software can then look at the good/bad tag of that byte before it pops it.

When the queue is full, the block does not overwrite anything. It drops the byte that arrived and every later byte until the next opening-flag strobe. The head byte and all stored bytes stay intact. A packet that has overflowed is therefore seen as a start-of-packet byte followed by another start-of-packet byte, with no end byte between them.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), `irq_stat`=00 and `irq`=0.
- R2: Bytes and their tags leave in the order they were accepted. `rd_data`/`rd_tag` always show the head entry, and a pop when the queue is empty has no effect.
- R3: `full` is 1 exactly when 16 entries are stored, and `empty` is 1 exactly when none are.
- R4: A write while full is discarded and puts the receiver into hunt mode, where every later byte is discarded until `open_flag` arrives. The head entry and all stored entries are unchanged, and no end-of-packet interrupt comes from a discarded byte.
- R5: Once a pulse on `open_flag` ends hunt mode, the bytes that follow are stored normally. The pulse takes effect from the next cycle.
- R6: Tags are stored unchanged: 01 first byte, 00 middle byte, 10 last byte of a good packet, 11 last byte of a bad packet. Tag bit 1 marks a packet end.
- R7: `irq_stat[0]` (end written) becomes 1 one cycle after a byte with tag bit 1 set is accepted.
- R8: `irq_stat[1]` (end at head) becomes 1 one cycle after a byte with tag bit 1 set becomes the head entry.
- R9: The status bits are sticky. A pulse on `irq_ack` clears them at the next edge, but an event in that same cycle is kept.
- R10: `irq` is the OR of the status bits that have their `irq_mask` bit set.
- R11: While `rx_en`=0 all writes are ignored, but pops, the head view and the status bits still work. After re-enabling, the receiver waits for `open_flag`.
- R12: After reset the receiver is in hunt mode and ignores writes until the first `open_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable for the write side |
| open_flag | input | 1 | One-cycle strobe: opening flag seen |
| wr_valid | input | 1 | Byte present from deframer |
| wr_data | input | 8 | Received byte |
| wr_tag | input | 2 | Packet-position tag of the byte |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head byte |
| rd_tag | output | 2 | Head tag |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds 16 entries |
| irq_ack | input | 1 | Read strobe of the interrupt status; clears it |
| irq_mask | input | 2 | Enable per status bit |
| irq_stat | output | 2 | Sticky status: bit0 end written, bit1 end at head |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `rd_pop` and `wr_valid` are plain one-cycle-per-byte strobes. They also assume that `open_flag` never comes in the same cycle as a byte, so that the deframer always finishes a flag before the first byte of a packet. The bench drives each of these strobes alone on a falling edge, one at a time, except in the one case it uses on purpose: an acknowledge together with an end-byte write. Packet contents come from an arithmetic pattern of packet number and byte index, so every expected byte and tag is recomputed independently.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;
  localparam int DATA_W  = 8;
  localparam int TAG_W   = 2;
  localparam int WORD_W  = DATA_W + TAG_W;
  localparam int END_BIT = 1;  // tag bit that marks a packet end

  typedef enum logic [TAG_W-1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } pkt_tag_e;

  localparam int IRQ_W    = 2;
  localparam int IRQ_WEND = 0;
  localparam int IRQ_HEND = 1;
endpackage

// File: rtl/pkt_rx_fifo_store.sv
module pkt_rx_fifo_store #(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 16   // power of two
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [WORD_W-1:0] slot_q [DEPTH];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_ptr_q[AW-1:0]] <= wr_word;
  end

  assign empty   = (wr_ptr_q == rd_ptr_q);
  assign full    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign rd_word = slot_q[rd_ptr_q[AW-1:0]];

  // R4: the write side never pushes into a full queue
  p_no_write_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en) else $error("write into full queue");
  // R2: the read side never pops an empty queue
  p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en) else $error("pop of empty queue");
  // R3: occupancy never exceeds the depth
  p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(wr_ptr_q - rd_ptr_q) <= PW'(DEPTH))) else $error("occupancy overrun");
endmodule

// File: rtl/pkt_rx_fifo_wrctl.sv
module pkt_rx_fifo_wrctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic open_flag,
  input  logic wr_valid,
  input  logic full,
  output logic wr_en,
  output logic hunt
);
  logic hunt_q, hunt_d;

  always_comb begin
    hunt_d = hunt_q;
    if (!rx_en)                          hunt_d = 1'b1;
    else if (open_flag)                  hunt_d = 1'b0;
    else if (wr_valid && full && !hunt_q) hunt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hunt_q <= 1'b1;
    else        hunt_q <= hunt_d;
  end

  assign wr_en = rx_en && !hunt_q && wr_valid && !full;
  assign hunt  = hunt_q;

  // R4: an arrival on a full queue leaves the receiver hunting
  p_overflow_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && wr_valid && full && !open_flag) |=> hunt_q) else $error("no hunt after overflow");
  // R11: disabling always forces a wait for a new opening flag
  p_disable_hunt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> hunt_q) else $error("no hunt after disable");
  // R5: an opening flag with the receiver on ends hunting
  p_flag_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && open_flag) |=> !hunt_q) else $error("flag did not resume");
endmodule

// File: rtl/pkt_rx_fifo_irq.sv
module pkt_rx_fifo_irq #(
  parameter int IRQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wend_evt,
  input  logic             head_end,
  input  logic             pop_done,
  input  logic             irq_ack,
  input  logic [IRQ_W-1:0] irq_mask,
  output logic [IRQ_W-1:0] irq_stat,
  output logic             irq
);
  import pkt_rx_fifo_pkg::*;

  logic             pop_q, head_end_q;
  logic             hend_evt;
  logic [IRQ_W-1:0] stat_q, stat_d, evt;

  // a packet end at the head is new if the head moved or just turned into an end
  assign hend_evt = head_end && (pop_q || !head_end_q);

  always_comb begin
    evt           = '0;
    evt[IRQ_WEND] = wend_evt;
    evt[IRQ_HEND] = hend_evt;
    stat_d        = (irq_ack ? '0 : stat_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      pop_q      <= 1'b0;
      head_end_q <= 1'b0;
    end else begin
      stat_q     <= stat_d;
      pop_q      <= pop_done;
      head_end_q <= head_end;
    end
  end

  assign irq_stat = stat_q;
  assign irq      = |(stat_q & irq_mask);

  // R7: a packet end written is always recorded
  p_wend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wend_evt |=> stat_q[IRQ_WEND]) else $error("end-written not recorded");
  // R9: status bits hold until acknowledged
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[IRQ_HEND] && !irq_ack) |=> stat_q[IRQ_HEND]) else $error("status lost");
  // R9: acknowledge clears when no new event arrives
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wend_evt) |=> !stat_q[IRQ_WEND]) else $error("ack did not clear");
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       open_flag,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] wr_tag,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic [1:0] rd_tag,
  output logic       empty,
  output logic       full,
  input  logic       irq_ack,
  input  logic [1:0] irq_mask,
  output logic [1:0] irq_stat,
  output logic       irq
);
  import pkt_rx_fifo_pkg::*;

  logic              wr_en, rd_en, hunt;
  logic [WORD_W-1:0] head_word;
  logic              head_end;

  assign rd_en = rd_pop && !empty;

  pkt_rx_fifo_wrctl i_wrctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .open_flag(open_flag),
    .wr_valid (wr_valid),
    .full     (full),
    .wr_en    (wr_en),
    .hunt     (hunt)
  );

  pkt_rx_fifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_word({wr_data, wr_tag}),
    .rd_en  (rd_en),
    .rd_word(head_word),
    .empty  (empty),
    .full   (full)
  );

  assign rd_tag   = head_word[TAG_W-1:0];
  assign rd_data  = head_word[WORD_W-1:TAG_W];
  assign head_end = !empty && head_word[END_BIT];

  pkt_rx_fifo_irq #(.IRQ_W(IRQ_W)) i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wend_evt(wr_en && wr_tag[END_BIT]),
    .head_end(head_end),
    .pop_done(rd_en),
    .irq_ack (irq_ack),
    .irq_mask(irq_mask),
    .irq_stat(irq_stat),
    .irq     (irq)
  );

  // R4: while full and not popped, the head view cannot change
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> ($stable(rd_data) && $stable(rd_tag))) else $error("head overwritten");
  // R12: while hunting nothing enters the queue
  p_hunt_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && empty && !rd_pop) |=> empty) else $error("write while hunting");
endmodule

// File: tb/test_pkt_rx_fifo.sv
`timescale 1ns/1ps
module test_pkt_rx_fifo;
  import pkt_rx_fifo_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, rx_en, open_flag, wr_valid, rd_pop, irq_ack, empty, full, irq;
  logic [7:0] wr_data, rd_data;
  logic [1:0] wr_tag, rd_tag, irq_mask, irq_stat;
  int total = 0, bad = 0;
  bit done = 0;

  pkt_rx_fifo i_pkt_rx_fifo (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int p, int i);
    return 8'((p * 37 + i * 5 + 3) & 255);
  endfunction

  function automatic logic [1:0] tag_of(int i, int len, bit badp);
    if (i == 0) return TAG_FIRST;
    if (i == len - 1) return badp ? TAG_END_BAD : TAG_END_OK;
    return TAG_MID;
  endfunction

  task automatic step(); @(negedge clk); endtask
  task automatic put(logic [7:0] d, logic [1:0] t);
    wr_valid = 1; wr_data = d; wr_tag = t; step(); wr_valid = 0;
  endtask
  task automatic flag(); open_flag = 1; step(); open_flag = 0; endtask
  task automatic pop(); rd_pop = 1; step(); rd_pop = 0; endtask
  task automatic ack(); irq_ack = 1; step(); irq_ack = 0; endtask
  task automatic send(int p, int len, bit badp);
    flag();
    for (int i = 0; i < len; i++) put(pat(p, i), tag_of(i, len, badp));
  endtask
  task automatic expect_pop(string req, logic [7:0] d, logic [1:0] t);
    chk(req, rd_data, d);
    chk(req, rd_tag, t);
    pop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_en = 1; open_flag = 0; wr_valid = 0; wr_data = 0; wr_tag = 0;
    rd_pop = 0; irq_ack = 0; irq_mask = 2'b11;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 irq_stat", irq_stat, 0); chk("R1 irq", irq, 0);

    // R12 bytes before any opening flag are dropped
    put(8'hAA, TAG_FIRST); put(8'h55, TAG_END_OK); step();
    chk("R12 empty", empty, 1); chk("R12 irq_stat", irq_stat, 0);

    // sweep of packet lengths, alternating good and bad ends
    for (int len = 2; len <= 16; len++) begin
      bit badp = len[0];
      send(len, len, badp); step();
      chk("R3 full", full, (len == 16));
      chk("R3 empty", empty, 0);
      chk("R7 end-written", irq_stat, 2'b01);
      ack();
      chk("R9 cleared", irq_stat, 0);
      for (int i = 0; i < len - 1; i++) expect_pop("R2 order", pat(len, i), tag_of(i, len, badp));
      step();
      chk("R8 end-at-head", irq_stat, 2'b10);
      chk("R6 end tag", rd_tag, badp ? 2'b11 : 2'b10);
      expect_pop("R2 last", pat(len, len - 1), tag_of(len - 1, len, badp));
      chk("R3 empty after drain", empty, 1);
      ack();
    end

    // R2 pop of empty queue does nothing
    pop(); chk("R2 empty pop", empty, 1); chk("R2 empty pop full", full, 0);
    send(50, 2, 0); step();
    chk("R2 head after empty pop", rd_data, pat(50, 0));
    expect_pop("R2", pat(50, 0), TAG_FIRST);
    expect_pop("R2", pat(50, 1), TAG_END_OK);
    ack();

    // R4 overflow: 20-byte packet, only 16 stored
    send(60, 20, 0); step();
    chk("R4 full", full, 1);
    chk("R4 head kept", rd_data, pat(60, 0));
    chk("R4 head tag", rd_tag, TAG_FIRST);
    chk("R4 dropped end gives no irq", irq_stat, 0);
    for (int i = 0; i < 3; i++) put(pat(61, i), tag_of(i, 3, 0));
    chk("R4 still full", full, 1);
    for (int i = 0; i < 4; i++) expect_pop("R4 stored", pat(60, i), tag_of(i, 20, 0));
    for (int i = 0; i < 3; i++) put(pat(61, i), tag_of(i, 3, 0));
    step();
    chk("R4 hunt keeps dropping", full, 0);
    chk("R4 no irq from dropped", irq_stat, 0);
    send(62, 3, 0); step();
    chk("R5 resumed", irq_stat[0], 1);
    chk("R3 full after resume", full, 0);
    for (int i = 4; i < 16; i++) expect_pop("R4 survivors", pat(60, i), TAG_MID);
    // R6 two first-byte tags with no end between them
    expect_pop("R6 second first tag", pat(62, 0), TAG_FIRST);
    expect_pop("R5", pat(62, 1), TAG_MID);
    expect_pop("R5", pat(62, 2), TAG_END_OK);
    chk("R3 empty", empty, 1);
    ack();

    // R10 masking
    irq_mask = 2'b00;
    send(70, 2, 0); step();
    chk("R10 masked", irq, 0);
    irq_mask = 2'b01; #1;
    chk("R10 end-written enabled", irq, 1);
    irq_mask = 2'b10; #1;
    chk("R10 head not end", irq, 0);
    pop(); step();
    chk("R10 end-at-head enabled", irq, 1);
    irq_mask = 2'b11;
    pop(); ack();

    // R9 acknowledge in the same cycle as an event keeps the event
    flag(); put(pat(75, 0), TAG_FIRST);
    irq_ack = 1; put(pat(75, 1), TAG_END_OK); irq_ack = 0;
    chk("R9 same-cycle event kept", irq_stat, 2'b01);
    pop(); pop(); ack();

    // R11 disable mid-packet
    flag(); put(pat(80, 0), TAG_FIRST); put(pat(80, 1), TAG_MID);
    rx_en = 0;
    put(pat(80, 2), TAG_MID); put(pat(80, 3), TAG_END_OK); step();
    chk("R11 no write while off", irq_stat, 0);
    expect_pop("R11 pop while off", pat(80, 0), TAG_FIRST);
    chk("R11 head view while off", rd_data, pat(80, 1));
    rx_en = 1;
    put(pat(81, 0), TAG_FIRST); put(pat(81, 1), TAG_END_OK); step();
    chk("R11 waits for flag", irq_stat, 0);
    send(82, 2, 1); step();
    chk("R11 after flag", irq_stat[0], 1);
    expect_pop("R11", pat(80, 1), TAG_MID);
    expect_pop("R11", pat(82, 0), TAG_FIRST);
    expect_pop("R11", pat(82, 1), TAG_END_BAD);
    chk("R11 empty", empty, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule